// File: doc/BRIEF.md
# Ultrasonic burst pulse generator

The block produces a finite train of pulses on one output pin to drive an ultrasonic transducer. Software programs three registers through a simple synchronous write port: a period divisor in clock cycles, a count of pulses, and a control word that carries the high-time width, an inversion bit and a start bit. Setting the start bit launches the burst. The start bit then doubles as a busy flag: it reads 1 until the last period has elapsed and then clears itself. Software cannot clear it.

The pin stays in high impedance until software sets an output-enable bit. The block signals this on a separate enable output that a pad cell uses. While a burst runs, the register contents are frozen so that the waveform in flight cannot be disturbed. A combinational read port returns any register selected by `rd_sel`.

Register selector encoding: 0 = control, 1 = period, 2 = count, 3 = unused.

Top module: `burst_pulse_gen`

## Requirements
- R1: A write to selector 0 with bit 15 set, while idle and with a nonzero count, starts a burst on the next clock edge. Bit 15 of the control readback reads 1 throughout the burst.
- R2: Bit 15 clears by itself after count × period cycles of burst. `burst_out` then returns to the inactive level.
- R3: A write of 0 to bit 15 during a burst has no effect, and the burst continues unchanged.
- R4: Every register write during a burst is ignored, including a second start and changes to width, inversion, period, count or enable.
- R5: Each period lasts divisor cycles, and a divisor of 0 counts as 1. The output is active for the first width cycles of each period. A width of 0 gives a constantly inactive output, and a width at or above the period gives a constantly active output.
- R6: Control bit 14 selects the polarity. With 0 the active level is 1; with 1 the active level is 0. When idle, `burst_out` holds the inactive level.
- R7: Control readback is {bit 15 busy, bit 14 inversion, bits 13:10 zero, bits 9:0 width}. Period readback holds the divisor in bits DIV_W-1:0, with the other bits zero. Count readback holds the count in bits CNT_W-1:0 and the output enable in bit 15, with the other bits zero. Selector 3 reads 0.
- R8: `burst_oe` follows the output-enable bit (count register bit 15). It is 0 after reset, which means high impedance.
- R9: Reset clears every register to 0, including a burst in progress.
- R10: A start with a count of 0 is ignored. Bit 15 stays 0 and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register selector for reads |
| rd_data | output | 16 | Selected register readback |
| burst_out | output | 1 | Pulse train level to the pad |
| burst_oe | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The assertions assume that writes arrive as single-cycle strobes with the selector and data stable around the clock edge, and that reset is applied synchronously. Under these assumptions the busy flag can only be raised by a start write and can only be lowered at the final period boundary. The bench drives every input on the falling edge and holds each write for exactly one cycle. Its random bursts use divisors from 0 to 12, widths from 0 to 14 and counts from 1 to 6, so they cover the zero, short and saturated-width corners within a bounded run time. Directed writes made in the middle of a burst check that the configuration stays frozen.

// File: rtl/burst_pkg.sv
`timescale 1ns/100ps
// Package: shared register layout for the burst pulse generator.
// Assumes a 16-bit register word; bit positions are fixed by the register map.
package burst_pkg;
    localparam int REG_W   = 16;
    localparam int WIDTH_W = 10;
    localparam int START_B = 15;
    localparam int INV_B   = 14;
    localparam int OE_B    = 15;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/burst_regs.sv
`timescale 1ns/100ps
// Module: register file and busy flag.
// Holds width, inversion, divisor, count and output enable, and freezes all of them
// while a burst runs. Assumes DIV_W <= 16 and CNT_W <= 15.
module burst_regs
    import burst_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [1:0]         rd_sel,
    input  logic               done,
    output logic [REG_W-1:0]   rd_data,
    output logic               busy,
    output logic               launch,
    output logic               invert,
    output logic               oe,
    output logic [WIDTH_W-1:0] width,
    output logic [DIV_W-1:0]   divisor,
    output logic [CNT_W-1:0]   count
);
    localparam int PAD_CNT = REG_W - 1 - CNT_W;

    logic idle_wr;

    // Start condition: a write to control with the start bit set, while idle and with a nonzero count
    always_comb begin
        idle_wr = wr_en && !busy;
        launch  = idle_wr && (reg_sel_e'(wr_sel) == SEL_CTRL)
                  && wr_data[START_B] && (count != '0);
    end

    // Register updates; busy is set by launch and cleared only by the timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            invert  <= 1'b0;
            oe      <= 1'b0;
            width   <= '0;
            divisor <= '0;
            count   <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
            end
        end else if (idle_wr) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    width  <= wr_data[WIDTH_W-1:0];
                    invert <= wr_data[INV_B];
                    if (launch) begin
                        busy <= 1'b1;
                    end
                end
                SEL_PERIOD: divisor <= wr_data[DIV_W-1:0];
                SEL_COUNT: begin
                    count <= wr_data[CNT_W-1:0];
                    oe    <= wr_data[OE_B];
                end
                default: ;
            endcase
        end
    end

    // Readback multiplexer
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CTRL:   rd_data = {busy, invert, 4'b0000, width};
            SEL_PERIOD: rd_data = REG_W'(divisor);
            SEL_COUNT:  rd_data = {oe, {PAD_CNT{1'b0}}, count};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/burst_timer.sv
`timescale 1ns/100ps
// Module: phase and pulse counters.
// The phase counter runs from 0 to divisor-1 (a divisor of 0 acts as 1). The pulse
// counter loads on launch and decrements at each period end. Assumes count != 0 at launch.
module burst_timer #(
    parameter int DIV_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             busy,
    input  logic [DIV_W-1:0] divisor,
    input  logic [CNT_W-1:0] count,
    output logic [DIV_W-1:0] phase,
    output logic [CNT_W-1:0] left,
    output logic             done
);
    logic [DIV_W-1:0] last_idx;
    logic             period_end;

    // Period boundary and final-period detection
    always_comb begin
        last_idx   = (divisor == '0) ? '0 : divisor - DIV_W'(1);
        period_end = busy && (phase == last_idx);
        done       = period_end && (left == CNT_W'(1));
    end

    // Counter sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            left  <= '0;
        end else if (launch) begin
            phase <= '0;
            left  <= count;
        end else if (period_end) begin
            phase <= '0;
            left  <= left - CNT_W'(1);
        end else if (busy) begin
            phase <= phase + DIV_W'(1);
        end
    end
endmodule

// File: rtl/burst_out_stage.sv
`timescale 1ns/100ps
// Module: output level and pad enable.
// The output is active while the phase is below the width, and the inversion bit maps
// active to 0. Assumes the phase is held at 0 when idle.
module burst_out_stage
    import burst_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic               busy,
    input  logic [DIV_W-1:0]   phase,
    input  logic [WIDTH_W-1:0] width,
    input  logic               invert,
    input  logic               oe,
    output logic               burst_out,
    output logic               burst_oe
);
    localparam int CMP_W = (DIV_W > WIDTH_W) ? DIV_W : WIDTH_W;

    logic active;

    // Active-window compare and polarity mapping
    always_comb begin
        active    = busy && (CMP_W'(phase) < CMP_W'(width));
        burst_out = active ^ invert;
        burst_oe  = oe;
    end
endmodule

// File: rtl/burst_pulse_gen.sv
`timescale 1ns/100ps
// Module: top of the ultrasonic burst pulse generator.
// Connects the register file, the timer and the output stage. Assumes single-cycle
// write strobes and a synchronous active-low reset.
module burst_pulse_gen
    import burst_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [15:0] rd_data,
    output logic        burst_out,
    output logic        burst_oe
);
    logic               busy;
    logic               launch;
    logic               done;
    logic               invert;
    logic               oe;
    logic [WIDTH_W-1:0] width;
    logic [DIV_W-1:0]   divisor;
    logic [CNT_W-1:0]   count;
    logic [DIV_W-1:0]   phase;
    logic [CNT_W-1:0]   left;

    burst_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .done(done), .rd_data(rd_data), .busy(busy), .launch(launch),
        .invert(invert), .oe(oe), .width(width), .divisor(divisor), .count(count)
    );

    burst_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .divisor(divisor),
        .count(count), .phase(phase), .left(left), .done(done)
    );

    burst_out_stage #(.DIV_W(DIV_W)) u_out (
        .busy(busy), .phase(phase), .width(width), .invert(invert), .oe(oe),
        .burst_out(burst_out), .burst_oe(burst_oe)
    );
endmodule

// File: rtl/burst_chk.sv
`timescale 1ns/100ps
// Module: assertion checker bound to burst_pulse_gen.
// Observes the busy flag, the counters and the frozen configuration.
module burst_chk #(
    parameter int DIV_W = 12,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [15:0]      wr_data,
    input logic             busy,
    input logic             done,
    input logic             invert,
    input logic [9:0]       width,
    input logic [DIV_W-1:0] divisor,
    input logic [DIV_W-1:0] phase,
    input logic [CNT_W-1:0] left,
    input logic             burst_out
);
    // R1
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_sel == 2'd0 && wr_data[15]));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    // R2
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(width) && $stable(divisor) && $stable(invert));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> burst_out == invert);

    // R5
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase < divisor) || (phase == '0));

    // R10
    left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> left != '0);
endmodule

bind burst_pulse_gen burst_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .done(done), .invert(invert), .width(width), .divisor(divisor),
    .phase(phase), .left(left), .burst_out(burst_out)
);

// File: tb/burst_pulse_gen_bench.sv
`timescale 1ns/100ps
// Bench: directed corner cases plus seeded random bursts, checked cycle by cycle.
module burst_pulse_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        burst_out;
    logic        burst_oe;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_pulse_gen u_burst_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .burst_out(burst_out), .burst_oe(burst_oe)
    );

    // Records one check and prints a failure line when it does not hold
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected pin level k cycles into a burst
    function automatic logic exp_level(input int k, input int p, input int w, input bit inv);
        int pe;
        pe = (p == 0) ? 1 : p;
        return ((k % pe) < w) ^ inv;
    endfunction

    // One-cycle register write; returns on the falling edge after the capture edge
    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reads a register at the current falling edge
    task automatic rd(input logic [1:0] sel, output logic [15:0] val);
        rd_sel = sel;
        #0.5;
        val = rd_data;
    endtask

    // Programs and runs a burst, checking each cycle; optionally writes during the burst
    task automatic run_burst(input int p, input int w, input int n, input bit inv,
                             input bit inject);
        int pe;
        int total;
        logic [15:0] v;
        pe = (p == 0) ? 1 : p;
        total = pe * n;
        wr(2'd1, 16'(p));
        wr(2'd2, 16'h8000 | 16'(n));
        wr(2'd0, {1'b1, inv, 4'b0000, 10'(w)});
        rd_sel = 2'd0;
        for (int k = 0; k < total; k++) begin
            #0.5;
            // R5 R6: waveform shape and polarity
            check(burst_out === exp_level(k, p, w, inv), "R5/R6 level",
                  32'(burst_out), 32'(exp_level(k, p, w, inv)));
            // R1: busy flag readable during burst
            check(rd_data[15] === 1'b1, "R1 busy bit", 32'(rd_data[15]), 32'd1);
            if (inject && k == 0) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = {1'b0, inv, 4'b0, 10'(w)}; // R3
            end else if (inject && k == 1) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = {1'b1, ~inv, 4'b0, 10'h3FF}; // R4
            end else if (inject && k == 2) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0001; // R4
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        #0.5;
        // R2: self-clear and inactive level after the last period
        check(rd_data[15] === 1'b0, "R2 busy cleared", 32'(rd_data[15]), 32'd0);
        check(burst_out === inv, "R2 idle level", 32'(burst_out), 32'(inv));
        check(rd_data[9:0] === 10'(w), "R4 width kept", 32'(rd_data[9:0]), 32'(w));
        rd(2'd2, v);
        check(v === (16'h8000 | 16'(n)), "R4 count kept", 32'(v), 32'(16'h8000 | 16'(n)));
        rd_sel = 2'd0;
    endtask

    // Watchdog: counts as a failure and still prints the summary
    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 R8: reset state
        rd(2'd0, v); check(v === 16'h0, "R9 ctrl reset", 32'(v), 32'h0);
        rd(2'd1, v); check(v === 16'h0, "R9 period reset", 32'(v), 32'h0);
        rd(2'd2, v); check(v === 16'h0, "R9 count reset", 32'(v), 32'h0);
        check(burst_oe === 1'b0, "R8 hi-z after reset", 32'(burst_oe), 32'd0);
        check(burst_out === 1'b0, "R6 idle level", 32'(burst_out), 32'd0);

        // R7: readback layout
        wr(2'd0, 16'h7FFF); rd(2'd0, v); check(v === 16'h43FF, "R7 ctrl readback", 32'(v), 32'h43FF);
        check(burst_out === 1'b1, "R6 inverted idle", 32'(burst_out), 32'd1);
        wr(2'd1, 16'hFFFF); rd(2'd1, v); check(v === 16'h0FFF, "R7 period readback", 32'(v), 32'h0FFF);
        wr(2'd2, 16'h7FFF); rd(2'd2, v); check(v === 16'h00FF, "R7 count readback", 32'(v), 32'h00FF);
        rd(2'd3, v); check(v === 16'h0, "R7 unused reads 0", 32'(v), 32'h0);
        // R8: enable follows bit 15 of count
        check(burst_oe === 1'b0, "R8 oe off", 32'(burst_oe), 32'd0);
        wr(2'd2, 16'h8003); check(burst_oe === 1'b1, "R8 oe on", 32'(burst_oe), 32'd1);

        // R10: zero count ignores start
        wr(2'd2, 16'h8000);
        wr(2'd0, 16'h8005);
        rd(2'd0, v); check(v[15] === 1'b0, "R10 no start", 32'(v[15]), 32'd0);
        check(burst_out === 1'b0, "R10 no pulse", 32'(burst_out), 32'd0);

        // Directed bursts: basic, injection, zero width, saturated width, inverted, zero divisor
        run_burst(5, 2, 3, 1'b0, 1'b0);
        run_burst(6, 3, 4, 1'b0, 1'b1);
        run_burst(4, 0, 2, 1'b0, 1'b0);
        run_burst(4, 9, 2, 1'b1, 1'b0);
        run_burst(3, 1, 3, 1'b1, 1'b1);
        run_burst(0, 1, 3, 1'b0, 1'b0);
        run_burst(1, 1, 1, 1'b0, 1'b0);

        // Random bursts
        for (int i = 0; i < 40; i++) begin
            run_burst(int'($urandom_range(0, 12)), int'($urandom_range(0, 14)),
                      int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        end

        // R9: reset during a burst
        wr(2'd1, 16'd8);
        wr(2'd2, 16'h8004);
        wr(2'd0, 16'h8003);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v); check(v === 16'h0, "R9 ctrl cleared mid-burst", 32'(v), 32'h0);
        rd(2'd2, v); check(v === 16'h0, "R9 count cleared", 32'(v), 32'h0);
        check(burst_oe === 1'b0, "R8 hi-z after reset", 32'(burst_oe), 32'd0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule